// File: doc/BRIEF.md
# Dual-Mode Interrupt Priority Router

This block gathers five interrupt requests and turns them into a single CPU interrupt priority level between 0 and 7, together with a matching autovector number. The five requests come from two general I/O controllers, an Ethernet controller, a serial controller and a non-maskable source. A one-bit routing-mode input selects one of two source-to-level tables: classic (input high) or alternate (input low). In classic mode the Ethernet request never reaches the CPU level. Instead it is passed to a separate expansion-slot interrupt output.

Internally the block keeps an 8-bit pending register, in which bit i stands for level i+1. A source sets or clears its own bit only in the cycle its request input changes. The bit it touches is chosen by the mode held at that moment. A registered priority encoder then reports the highest pending level.

A pulse on the NMI trigger starts a small state machine with two states, IDLE and HOLD. The machine holds the non-maskable request active for HOLD_MS milliseconds, counted as CYC_PER_MS clock cycles per millisecond. The transitions are:
- reset goes to IDLE;
- IDLE to HOLD on a trigger, loading the counter;
- HOLD to HOLD on a trigger, reloading the counter;
- HOLD to HOLD with no trigger, decrementing the counter;
- HOLD to IDLE when the counter is exhausted.

Top module: `irq_prio_router`

## Requirements
- R1: While reset is asserted, cpu_level and cpu_vector are 0 and the routing mode register is forced to alternate, so slot_irq is 0 even with req_enet and mode_classic both high.
- R2: In classic mode, req_via1 maps to level 1, req_via2 to level 2, req_serial to level 4 and the held NMI to level 7. No source ever sets level 5 or the unused pending bit 7.
- R3: In classic mode, req_enet sets no level and slot_irq follows req_enet.
- R4: In alternate mode, req_via1 maps to level 6, req_via2 to level 2, req_enet to level 3, req_serial to level 4 and the held NMI to level 7. slot_irq stays 0.
- R5: A request that rises sets its pending bit and a request that falls clears it. cpu_level is the highest pending level.
- R6: cpu_vector equals 24 plus cpu_level when cpu_level is nonzero, and is 0 when no bit is pending.
- R7: The mode input is registered. A request change present before clock edge N updates the pending bit at edge N, and cpu_level and cpu_vector follow at edge N+1.
- R8: A mode change does not move bits that are already pending. A request that falls in the other mode clears the bit of that other mode's table.
- R9: An nmi_trig pulse makes the NMI request active for CYC_PER_MS*HOLD_MS cycles. A new trigger during the hold restarts the full interval.
- R10: Reset cancels an NMI hold in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_classic | input | 1 | Routing mode: 1 classic, 0 alternate |
| req_via1 | input | 1 | First I/O controller request (level) |
| req_via2 | input | 1 | Second I/O controller request (level) |
| req_enet | input | 1 | Ethernet request (level) |
| req_serial | input | 1 | Serial controller request (level) |
| nmi_trig | input | 1 | Starts or restarts the NMI hold |
| cpu_level | output | 3 | Highest pending priority level, 0 for none |
| cpu_vector | output | 8 | Autovector number, 24+level, or 0 |
| slot_irq | output | 1 | Expansion-slot interrupt in classic mode |

## Verification
The assertions assume that the requests are synchronous level signals and that nmi_trig is sampled on a clock edge. They also assume that no request is active in a way that would set level 8, since no source maps there. The bench changes inputs only on the falling clock edge. After each change it waits at least three cycles, so that the registered mode, the pending register and the encoder have all settled before the outputs are compared. Mode switches are made only while the requests stay steady, so the table used for each request change is always known.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;

    localparam int NUM_SRC   = 5;
    localparam int PEND_W    = 8;
    localparam int VEC_BASE  = 24;

    localparam logic [2:0] SRC_VIA1   = 3'd0;
    localparam logic [2:0] SRC_VIA2   = 3'd1;
    localparam logic [2:0] SRC_ENET   = 3'd2;
    localparam logic [2:0] SRC_SERIAL = 3'd3;
    localparam logic [2:0] SRC_NMI    = 3'd4;

    typedef enum logic {
        NMI_IDLE = 1'b0,
        NMI_HOLD = 1'b1
    } nmi_state_e;

    typedef struct packed {
        logic       hit;
        logic [2:0] idx;
    } route_t;

    // Pending-bit index per source; bit i stands for level i+1.
    function automatic route_t route_of(input logic [2:0] src, input logic classic);
        route_t r;
        r = '{hit: 1'b0, idx: 3'd0};
        case (src)
            SRC_VIA1:   r = classic ? '{1'b1, 3'd0} : '{1'b1, 3'd5};
            SRC_VIA2:   r = '{1'b1, 3'd1};
            SRC_ENET:   r = classic ? '{1'b0, 3'd0} : '{1'b1, 3'd2};
            SRC_SERIAL: r = '{1'b1, 3'd3};
            SRC_NMI:    r = '{1'b1, 3'd6};
            default:    r = '{1'b0, 3'd0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_nmi_stretch.sv
`timescale 1ns/1ps
module irq_nmi_stretch
    import irq_router_pkg::*;
#(
    parameter int HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    nmi_state_e    st_q, st_nxt;
    logic [CW-1:0] cnt_q, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= NMI_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = cnt_q;
        unique case (st_q)
            NMI_IDLE: begin
                if (trig) begin
                    st_nxt  = NMI_HOLD;
                    cnt_nxt = LAST;
                end
            end
            NMI_HOLD: begin
                if (trig) begin
                    cnt_nxt = LAST;
                end else if (cnt_q == '0) begin
                    st_nxt = NMI_IDLE;
                end else begin
                    cnt_nxt = cnt_q - CW'(1);
                end
            end
        endcase
    end

    always_comb begin
        active = (st_q == NMI_HOLD);
    end

endmodule

// File: rtl/irq_pend_track.sv
`timescale 1ns/1ps
module irq_pend_track
    import irq_router_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int PW   = PEND_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            classic,
    input  logic [NSRC-1:0] req,
    output logic [PW-1:0]   pend
);
    logic [NSRC-1:0] chg;
    logic [PW-1:0]   pend_q, pend_nxt;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic prv_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prv_q <= 1'b0;
            else        prv_q <= req[g];
        end
        assign chg[g] = prv_q ^ req[g];
    end

    always_comb begin
        route_t rt;
        pend_nxt = pend_q;
        for (int s = 0; s < NSRC; s++) begin
            rt = route_of(3'(s), classic);
            if (chg[s] && rt.hit) pend_nxt[rt.idx] = req[s];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nxt;
    end

    assign pend = pend_q;

endmodule

// File: rtl/irq_level_enc.sv
`timescale 1ns/1ps
module irq_level_enc
    import irq_router_pkg::*;
#(
    parameter int PW    = PEND_W,
    parameter int VBASE = VEC_BASE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pend,
    output logic [2:0]    level,
    output logic [7:0]    vector
);
    localparam int HW = $clog2(PW + 1);

    logic [HW-1:0] hi;

    always_comb begin
        hi = '0;
        for (int i = 0; i < PW; i++) begin
            if (pend[i]) hi = HW'(i + 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level  <= '0;
            vector <= '0;
        end else begin
            level  <= hi[2:0];
            vector <= (hi == '0) ? 8'd0 : 8'(VBASE) + 8'(hi);
        end
    end

endmodule

// File: rtl/irq_prio_router.sv
`timescale 1ns/1ps
module irq_prio_router
    import irq_router_pkg::*;
#(
    parameter int CYC_PER_MS = 100000,
    parameter int HOLD_MS    = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_classic,
    input  logic       req_via1,
    input  logic       req_via2,
    input  logic       req_enet,
    input  logic       req_serial,
    input  logic       nmi_trig,
    output logic [2:0] cpu_level,
    output logic [7:0] cpu_vector,
    output logic       slot_irq
);
    localparam int HOLD_CYC = CYC_PER_MS * HOLD_MS;

    logic               mode_q;
    logic               nmi_active;
    logic [NUM_SRC-1:0] req_vec;
    logic [PEND_W-1:0]  pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_classic;
    end

    irq_nmi_stretch #(.HOLD_CYC(HOLD_CYC)) u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (nmi_trig),
        .active (nmi_active)
    );

    assign req_vec = {nmi_active, req_serial, req_enet, req_via2, req_via1};

    irq_pend_track #(.NSRC(NUM_SRC), .PW(PEND_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .classic (mode_q),
        .req     (req_vec),
        .pend    (pend_q)
    );

    irq_level_enc #(.PW(PEND_W), .VBASE(VEC_BASE)) u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend_q),
        .level  (cpu_level),
        .vector (cpu_vector)
    );

    assign slot_irq = mode_q & req_enet;

endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_classic,
    input logic       nmi_trig,
    input logic       nmi_active,
    input logic [7:0] pend,
    input logic [2:0] cpu_level,
    input logic [7:0] cpu_vector,
    input logic       slot_irq
);
    assert_vec_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level == 3'd0) |-> (cpu_vector == 8'd0));

    assert_vec_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level != 3'd0) |-> (cpu_vector == 8'd24 + 8'(cpu_level)));

    assert_slot_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_classic) |-> !slot_irq);

    assert_nmi_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_trig |=> nmi_active);

    assert_nmi_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pend[6]) |-> (cpu_level == 3'd7));

    assert_idle_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend) == 8'd0) |-> (cpu_level == 3'd0));

    assert_no_lvl5_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pend[4] && !pend[7]);

endmodule

bind irq_prio_router irq_router_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_classic (mode_classic),
    .nmi_trig     (nmi_trig),
    .nmi_active   (nmi_active),
    .pend         (pend_q),
    .cpu_level    (cpu_level),
    .cpu_vector   (cpu_vector),
    .slot_irq     (slot_irq)
);

// File: tb/irq_prio_router_test.sv
`timescale 1ns/1ps
module irq_prio_router_test;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       mode_classic = 1'b0;
    logic       req_via1 = 1'b0, req_via2 = 1'b0, req_enet = 1'b0, req_serial = 1'b0;
    logic       nmi_trig = 1'b0;
    logic [2:0] cpu_level;
    logic [7:0] cpu_vector;
    logic       slot_irq;

    typedef struct {
        logic [2:0] lvl;
        logic [7:0] vec;
        logic       slot;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    irq_prio_router #(.CYC_PER_MS(2), .HOLD_MS(100)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_classic (mode_classic),
        .req_via1     (req_via1),
        .req_via2     (req_via2),
        .req_enet     (req_enet),
        .req_serial   (req_serial),
        .nmi_trig     (nmi_trig),
        .cpu_level    (cpu_level),
        .cpu_vector   (cpu_vector),
        .slot_irq     (slot_irq)
    );

    // Monitor: compares queued expectations just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (cpu_level !== e.lvl || cpu_vector !== e.vec || slot_irq !== e.slot) begin
                    n_bad++;
                    $display("FAIL %s: level/vector/slot got %0d/%0d/%0d expected %0d/%0d/%0d",
                             e.tag, cpu_level, cpu_vector, slot_irq, e.lvl, e.vec, e.slot);
                end
            end
        end
    end

    task automatic expect_out(input logic [2:0] l, input logic s, input string tag);
        exp_t e;
        e.lvl  = l;
        e.vec  = (l == 3'd0) ? 8'd0 : 8'd24 + 8'(l);
        e.slot = s;
        e.tag  = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic v1, input logic v2, input logic en,
                         input logic ser, input logic md);
        @(negedge clk);
        req_via1 = v1; req_via2 = v2; req_enet = en; req_serial = ser; mode_classic = md;
        wait_cyc(3);
    endtask

    task automatic pulse_nmi();
        @(negedge clk);
        nmi_trig = 1'b1;
        @(negedge clk);
        nmi_trig = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, mode forced to alternate hides slot_irq
        mode_classic = 1'b1;
        req_enet = 1'b1;
        wait_cyc(3);
        expect_out(3'd0, 1'b0, "R1 reset outputs and mode");
        req_enet = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(3);
        expect_out(3'd0, 1'b0, "R1 idle after reset");

        // Classic mode mapping
        drive(1, 0, 0, 0, 1); expect_out(3'd1, 1'b0, "R2 via1 classic level 1");
        drive(1, 1, 0, 0, 1); expect_out(3'd2, 1'b0, "R5 via2 over via1");
        drive(1, 1, 0, 1, 1); expect_out(3'd4, 1'b0, "R2 serial classic level 4");
        drive(1, 1, 1, 1, 1); expect_out(3'd4, 1'b1, "R3 enet classic to slot");
        drive(1, 1, 0, 1, 1); expect_out(3'd4, 1'b0, "R3 slot follows enet low");
        drive(1, 1, 0, 0, 1); expect_out(3'd2, 1'b0, "R5 serial cleared");
        drive(1, 0, 0, 0, 1); expect_out(3'd1, 1'b0, "R5 via2 cleared");
        drive(0, 0, 0, 0, 1); expect_out(3'd0, 1'b0, "R6 none pending vector 0");

        // R7: latency of two edges
        @(negedge clk);
        req_via2 = 1'b1;
        @(negedge clk);
        expect_out(3'd0, 1'b0, "R7 not yet after one edge");
        expect_out(3'd2, 1'b0, "R7 visible after second edge");

        // Alternate mode mapping (via2 still high)
        drive(0, 1, 0, 0, 0); expect_out(3'd2, 1'b0, "R4 via2 alternate level 2");
        drive(1, 1, 0, 0, 0); expect_out(3'd6, 1'b0, "R4 via1 alternate level 6");
        drive(1, 1, 1, 0, 0); expect_out(3'd6, 1'b0, "R4 enet alternate no slot");
        drive(0, 1, 1, 0, 0); expect_out(3'd3, 1'b0, "R4 enet alternate level 3");
        drive(0, 1, 1, 1, 0); expect_out(3'd4, 1'b0, "R4 serial alternate level 4");
        drive(0, 1, 1, 0, 0); expect_out(3'd3, 1'b0, "R5 serial cleared alternate");
        drive(0, 1, 0, 0, 0); expect_out(3'd2, 1'b0, "R5 enet cleared alternate");
        drive(0, 0, 0, 0, 0); expect_out(3'd0, 1'b0, "R5 all cleared alternate");

        // R8: mode change keeps pending bits
        drive(1, 0, 0, 0, 0); expect_out(3'd6, 1'b0, "R8 via1 set in alternate");
        drive(1, 0, 0, 0, 1); expect_out(3'd6, 1'b0, "R8 level kept across mode change");
        drive(0, 0, 0, 0, 1); expect_out(3'd6, 1'b0, "R8 classic clear hits level 1 bit only");
        drive(0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0); expect_out(3'd0, 1'b0, "R8 cleared back in alternate");
        drive(0, 0, 1, 0, 0); expect_out(3'd3, 1'b0, "R8 enet set in alternate");
        drive(0, 0, 1, 0, 1); expect_out(3'd3, 1'b1, "R8 enet bit kept, slot in classic");
        drive(0, 0, 0, 0, 1); expect_out(3'd3, 1'b0, "R8 classic enet fall leaves bit");
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 1, 0, 0);
        drive(0, 0, 0, 0, 0); expect_out(3'd0, 1'b0, "R8 enet bit cleared in alternate");

        // R9: NMI hold of 200 cycles
        pulse_nmi();
        wait_cyc(4);
        expect_out(3'd7, 1'b0, "R9 nmi level 7");
        wait_cyc(194);
        expect_out(3'd7, 1'b0, "R9 nmi still held near end");
        wait_cyc(3);
        expect_out(3'd0, 1'b0, "R9 nmi released after hold");

        // R9: retrigger restarts the hold
        wait_cyc(5);
        pulse_nmi();
        wait_cyc(99);
        pulse_nmi();
        wait_cyc(148);
        expect_out(3'd7, 1'b0, "R9 retrigger extends hold");
        wait_cyc(60);
        expect_out(3'd0, 1'b0, "R9 retriggered hold ends");

        // R10: reset cancels hold
        pulse_nmi();
        wait_cyc(10);
        expect_out(3'd7, 1'b0, "R10 hold in progress");
        rst_n = 1'b0;
        wait_cyc(3);
        expect_out(3'd0, 1'b0, "R1 outputs cleared in reset");
        rst_n = 1'b1;
        wait_cyc(5);
        expect_out(3'd0, 1'b0, "R10 hold cancelled");
        wait_cyc(20);
        expect_out(3'd0, 1'b0, "R10 no late nmi");

        wait_cyc(2);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule